// File: doc/BRIEF.md
# RS-485 UART Transmitter with Driver-Enable Timing

This block serialises data words onto a UART line and controls the enable pin of an external half-duplex line driver. A word arrives through a valid/ready handshake. The block sends it as one frame: a start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then a stop period. The data length, parity mode and stop length are all selectable. All timing is counted in pulses of an oversampling tick at sixteen times the baud rate. An external baud generator supplies this tick.

The driver-enable output turns on a programmable number of sixteenth-bit ticks before the start bit. It turns off a programmable number of ticks after the stop period ends. A word accepted while that release delay is still running is sent straight away, and the driver stays enabled. Both pins have their own polarity control. A feature bit can keep the enable pin permanently inactive.

Top module: `uart_de_tx`

## Requirements
- R1: After reset, `in_ready` is high. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle or in the driver release delay. It is low in the cycle after any acceptance.
- R2: Only clock edges with `tick16` high advance time, and a tick on the acceptance edge is not counted. The idle line is logic 1. The start bit is logic 0 for 16 ticks. The data bits then follow, least significant bit first, each lasting 16 ticks.
- R3: `cfg_data_len` gives the number of data bits as a binary value from 5 to 9. Values below 5 act as 5 and values above 9 act as 9. Bits of `in_data` above the data length are not sent.
- R4: `cfg_parity` selects the parity mode: 0 = none, 1 = odd, 2 = even, and 3 acts as none. A parity bit of 16 ticks follows the last data bit. Counting the data bits and the parity bit together, the number of ones is even in even mode and odd in odd mode.
- R5: `cfg_stop` selects the stop period at logic 1: 0 = 8 ticks, 1 = 16 ticks, 2 = 24 ticks, 3 = 32 ticks.
- R6: With the driver enabled, DE becomes active on the acceptance edge from idle. The start bit begins exactly `cfg_de_lead` ticks later. A lead of 0 starts the frame on the acceptance edge.
- R7: With the driver enabled, DE becomes inactive exactly `cfg_de_lag` ticks after the stop period ends. A lag of 0 releases it at the end of the stop period.
- R8: With `cfg_de_en` = 0, DE stays inactive for the whole frame and no lead time is inserted.
- R9: A word accepted during the release delay starts its start bit on the acceptance edge, which is the first cycle after the stop period ends. DE stays active between the two frames.
- R10: `tx_out` is the logical line level XOR `cfg_tx_inv`. `de_out` is the logical enable XOR `cfg_de_inv`. Both polarity inputs act at once, even while idle.
- R11: Data length, parity, stop length, lead, lag and the enable bit are sampled on the acceptance edge. Changing them later has no effect on the frame already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x baud rate |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted |
| in_data | input | DATA_W | Word to send, LSB first |
| cfg_data_len | input | 4 | Data bit count, 5 to 9 |
| cfg_parity | input | 2 | 0 none, 1 odd, 2 even |
| cfg_stop | input | 2 | Stop period: 8, 16, 24 or 32 ticks |
| cfg_de_en | input | 1 | Driver-enable output in use |
| cfg_de_lead | input | TIME_W | Ticks from DE active to start bit |
| cfg_de_lag | input | TIME_W | Ticks from end of stop period to DE release |
| cfg_tx_inv | input | 1 | Invert serial output |
| cfg_de_inv | input | 1 | Invert driver-enable output |
| tx_out | output | 1 | Serial line |
| de_out | output | 1 | Driver enable |

## Verification
The bench builds the block with its defaults: 9-bit words, a 16x oversampling rate and 5-bit lead and lag fields. This makes the full 9-bit data length reachable, along with the 31-tick extremes of lead and lag and the 8-tick half stop period. The tick is pulsed on every fourth clock. This spacing makes sure a transition delayed by one clock never crosses a tick boundary, so the bench can timestamp each line edge in ticks. From those timestamps it checks lead, lag, the zero-gap back-to-back start and every bit position against values computed from the requirements.

// File: rtl/uart_de_pkg.sv
package uart_de_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_RSVD = 2'd3
    } parity_e;

    typedef enum logic [1:0] {
        STOP_HALF     = 2'd0,
        STOP_ONE      = 2'd1,
        STOP_ONE_HALF = 2'd2,
        STOP_TWO      = 2'd3
    } stop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_LAG
    } seq_e;

    // Last tick index of the stop period: half-bit steps of the oversampling rate.
    function automatic int stop_last(stop_e s, int osr);
        return ((int'(s) + 1) * osr) / 2 - 1;
    endfunction

    function automatic logic parity_on(parity_e p);
        return (p == PAR_ODD) || (p == PAR_EVEN);
    endfunction

endpackage

// File: rtl/uart_de_frame.sv
module uart_de_frame
    import uart_de_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int LEN_MIN = 5,
    localparam int NB_W   = $clog2(DATA_W + 2)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [3:0]        len_code,
    input  parity_e           par,
    output logic [DATA_W:0]   bits,
    output logic [NB_W-1:0]   nbits
);

    int  len;
    logic ones;

    always_comb begin
        if (int'(len_code) < LEN_MIN)      len = LEN_MIN;
        else if (int'(len_code) > DATA_W)  len = DATA_W;
        else                               len = int'(len_code);

        ones = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < len) ones = ones ^ data[i];
        end

        bits = '1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < len) bits[i] = data[i];
        end
        if (parity_on(par)) begin
            bits[len] = (par == PAR_ODD) ? ~ones : ones;
        end

        nbits = NB_W'(len + (parity_on(par) ? 1 : 0));
    end

endmodule

// File: rtl/uart_de_seq.sv
module uart_de_seq
    import uart_de_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OSR    = 16,
    parameter int TIME_W = 5,
    localparam int NB_W  = $clog2(DATA_W + 2),
    localparam int CNT_W = ($clog2(2 * OSR) > TIME_W) ? $clog2(2 * OSR) : TIME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W:0]   frame_bits,
    input  logic [NB_W-1:0]   frame_nbits,
    input  stop_e             stop_sel,
    input  logic              de_en_in,
    input  logic [TIME_W-1:0] lead_in,
    input  logic [TIME_W-1:0] lag_in,
    output logic              tx_line,
    output logic              de_line
);

    seq_e              state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, limit;
    logic [NB_W-1:0]   idx_q, idx_n, nbits_q, nbits_n;
    logic [DATA_W:0]   shreg_q, shreg_n;
    logic [CNT_W-1:0]  stop_last_q, stop_last_n;
    logic [TIME_W-1:0] lead_q, lead_n, lag_q, lag_n;
    logic              de_en_q, de_en_n;
    logic              tx_q, tx_n, de_q, de_n;
    logic              accept, last;

    assign in_ready = (state_q == ST_IDLE) || (state_q == ST_LAG);
    assign accept   = in_valid && in_ready;

    always_comb begin
        case (state_q)
            ST_LEAD: limit = CNT_W'(lead_q - 1'b1);
            ST_STOP: limit = stop_last_q;
            ST_LAG:  limit = CNT_W'(lag_q - 1'b1);
            default: limit = CNT_W'(OSR - 1);
        endcase
        last = (cnt_q == limit);
    end

    always_comb begin
        state_n     = state_q;
        cnt_n       = cnt_q;
        idx_n       = idx_q;
        nbits_n     = nbits_q;
        shreg_n     = shreg_q;
        stop_last_n = stop_last_q;
        lead_n      = lead_q;
        lag_n       = lag_q;
        de_en_n     = de_en_q;

        case (state_q)
            ST_IDLE, ST_LAG: begin
                if (accept) begin
                    shreg_n     = frame_bits;
                    nbits_n     = frame_nbits;
                    stop_last_n = CNT_W'(stop_last(stop_sel, OSR));
                    lead_n      = lead_in;
                    lag_n       = lag_in;
                    de_en_n     = de_en_in;
                    cnt_n       = '0;
                    idx_n       = '0;
                    if (state_q == ST_IDLE && de_en_in && lead_in != '0)
                        state_n = ST_LEAD;
                    else
                        state_n = ST_START;
                end else if (state_q == ST_LAG && tick) begin
                    if (last) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_LEAD, ST_START: begin
                if (tick) begin
                    if (last) begin
                        state_n = (state_q == ST_LEAD) ? ST_START : ST_DATA;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (last) begin
                        cnt_n   = '0;
                        shreg_n = shreg_q >> 1;
                        idx_n   = idx_q + 1'b1;
                        if (idx_q == nbits_q - 1'b1) state_n = ST_STOP;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (last) begin
                        cnt_n   = '0;
                        state_n = (de_en_q && lag_q != '0) ? ST_LAG : ST_IDLE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase

        tx_n = (state_n != ST_START) && ((state_n != ST_DATA) || shreg_n[0]);
        de_n = de_en_n && (state_n != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            idx_q       <= '0;
            nbits_q     <= '0;
            shreg_q     <= '1;
            stop_last_q <= '0;
            lead_q      <= '0;
            lag_q       <= '0;
            de_en_q     <= 1'b0;
            tx_q        <= 1'b1;
            de_q        <= 1'b0;
        end else begin
            state_q     <= state_n;
            cnt_q       <= cnt_n;
            idx_q       <= idx_n;
            nbits_q     <= nbits_n;
            shreg_q     <= shreg_n;
            stop_last_q <= stop_last_n;
            lead_q      <= lead_n;
            lag_q       <= lag_n;
            de_en_q     <= de_en_n;
            tx_q        <= tx_n;
            de_q        <= de_n;
        end
    end

    assign tx_line = tx_q;
    assign de_line = de_q;

    // R1
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    // R2
    tx_low_framed_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_q |-> (state_q == ST_START || state_q == ST_DATA));

    // R6
    de_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_q) && de_en_q) |-> de_q);

    // R8
    de_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !de_en_q |-> !de_q);

    // R9
    lag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAG && in_valid && de_en_in) |=> (de_q && !tx_q));

    // R5
    stop_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP) |-> (cnt_q <= stop_last_q));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START || state_q == ST_DATA || state_q == ST_STOP)
        |=> ($stable(stop_last_q) && $stable(nbits_q) && $stable(lag_q)));

endmodule

// File: rtl/uart_de_pol.sv
module uart_de_pol (
    input  logic lvl,
    input  logic inv,
    output logic pin
);

    assign pin = lvl ^ inv;

endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx
    import uart_de_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OSR    = 16,
    parameter int TIME_W = 5,
    localparam int NB_W  = $clog2(DATA_W + 2),
    localparam int NPINS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [3:0]        cfg_data_len,
    input  logic [1:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_de_en,
    input  logic [TIME_W-1:0] cfg_de_lead,
    input  logic [TIME_W-1:0] cfg_de_lag,
    input  logic              cfg_tx_inv,
    input  logic              cfg_de_inv,
    output logic              tx_out,
    output logic              de_out
);

    logic [DATA_W:0]  fbits;
    logic [NB_W-1:0]  fnbits;
    logic             tx_line, de_line;
    logic [NPINS-1:0] lvl, inv, pin;

    uart_de_frame #(.DATA_W(DATA_W)) u_frame (
        .data     (in_data),
        .len_code (cfg_data_len),
        .par      (parity_e'(cfg_parity)),
        .bits     (fbits),
        .nbits    (fnbits)
    );

    uart_de_seq #(.DATA_W(DATA_W), .OSR(OSR), .TIME_W(TIME_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .frame_bits  (fbits),
        .frame_nbits (fnbits),
        .stop_sel    (stop_e'(cfg_stop)),
        .de_en_in    (cfg_de_en),
        .lead_in     (cfg_de_lead),
        .lag_in      (cfg_de_lag),
        .tx_line     (tx_line),
        .de_line     (de_line)
    );

    assign lvl = {de_line, tx_line};
    assign inv = {cfg_de_inv, cfg_tx_inv};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        uart_de_pol u_pol (
            .lvl (lvl[g]),
            .inv (inv[g]),
            .pin (pin[g])
        );
    end

    assign tx_out = pin[0];
    assign de_out = pin[1];

endmodule

// File: tb/sim_uart_de_tx.sv
`timescale 1ns/1ps
module sim_uart_de_tx;

    typedef struct {
        int  data;
        int  len;
        int  par;
        int  stop_t;
        int  lead_eff;
        int  lag;
        bit  de_en;
        bit  b2b;
        int  acc_t;
    } item_t;

    logic       clk = 0, rst = 1, tick16 = 0, in_valid = 0;
    logic       in_ready, tx_out, de_out;
    logic [8:0] in_data = '0;
    logic [3:0] cfg_data_len = 4'd8;
    logic [1:0] cfg_parity = 0, cfg_stop = 1;
    logic       cfg_de_en = 0, cfg_tx_inv = 0, cfg_de_inv = 0;
    logic [4:0] cfg_de_lead = 0, cfg_de_lag = 0;

    bit  tx_inv_b = 0, de_inv_b = 0;
    int  tcnt = 0, nchk = 0, nfail = 0, sent = 0, done = 0;
    int  de_rise_t = 0, fall_cnt = 0, exp_drop = 0, last_te = 0, fall_at_last = 0;
    bit  drop_valid = 0, de_prev = 0;
    item_t q[$];

    always #10 clk = ~clk;

    uart_de_tx u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_data_len(cfg_data_len), .cfg_parity(cfg_parity),
        .cfg_stop(cfg_stop), .cfg_de_en(cfg_de_en), .cfg_de_lead(cfg_de_lead),
        .cfg_de_lag(cfg_de_lag), .cfg_tx_inv(cfg_tx_inv), .cfg_de_inv(cfg_de_inv),
        .tx_out(tx_out), .de_out(de_out)
    );

    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph = (ph + 1) % 4;
            tick16 = (ph == 0);
        end
    end

    always @(posedge clk) if (!rst && tick16) tcnt <= tcnt + 1;

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit tx_log();
        return tx_out ^ tx_inv_b;
    endfunction

    function automatic bit de_log();
        return de_out ^ de_inv_b;
    endfunction

    // One negedge step of the monitor, with DE edge tracking.
    task automatic step();
        @(negedge clk);
        if (de_log() && !de_prev) de_rise_t = tcnt;
        if (!de_log() && de_prev) begin
            fall_cnt++;
            // R7
            chk(drop_valid, "R7 unexpected DE release", tcnt, -1);
            if (drop_valid) chk(tcnt == exp_drop, "R7 DE release tick", tcnt, exp_drop);
            drop_valid = 0;
        end
        de_prev = de_log();
    endtask

    task automatic wait_t(int target);
        do step(); while (tcnt < target);
    endtask

    // Monitor: decodes frames and compares them with the scoreboard queue.
    initial begin
        item_t it;
        int ts, nb, te, got, pbit, ones, exp_d;
        @(negedge clk);
        while (rst) @(negedge clk);
        de_prev = de_log();
        forever begin
            do step(); while (tx_log() != 1'b0);
            ts = tcnt;
            drop_valid = 0;
            if (q.size() == 0) begin
                chk(0, "R2 unexpected frame", ts, -1);
                continue;
            end
            it = q.pop_front();
            // R6 R8: start delay from acceptance
            chk(ts == it.acc_t + it.lead_eff, "R6 start tick", ts, it.acc_t + it.lead_eff);
            if (it.de_en && it.lead_eff > 0)
                chk(de_rise_t == it.acc_t, "R6 DE active tick", de_rise_t, it.acc_t);
            if (it.b2b) begin
                // R9
                chk(ts == last_te, "R9 back-to-back start", ts, last_te);
                chk(fall_cnt == fall_at_last, "R9 DE held", fall_cnt, fall_at_last);
            end
            wait_t(ts + 8);
            chk(tx_log() == 1'b0, "R2 start bit", tx_log(), 0);
            // R1
            chk(in_ready == 1'b0, "R1 busy not ready", in_ready, 0);
            got = 0;
            ones = 0;
            for (int k = 0; k < it.len; k++) begin
                wait_t(ts + 8 + 16 * (k + 1));
                got = got | (int'(tx_log()) << k);
                ones = ones + int'(tx_log());
            end
            exp_d = it.data & ((1 << it.len) - 1);
            // R2 R3
            chk(got == exp_d, "R2/R3 data bits", got, exp_d);
            nb = 1 + it.len;
            if (it.par == 1 || it.par == 2) begin
                wait_t(ts + 8 + 16 * nb);
                pbit = int'(tx_log());
                // R4
                chk(((ones + pbit) % 2) == (it.par == 1 ? 1 : 0), "R4 parity", pbit, -1);
                nb++;
            end
            wait_t(ts + 16 * nb + it.stop_t / 2);
            // R5
            chk(tx_log() == 1'b1, "R5 stop level", tx_log(), 1);
            // R8
            chk(de_log() == it.de_en, "R8 DE during frame", de_log(), it.de_en);
            te = ts + 16 * nb + it.stop_t;
            last_te = te;
            fall_at_last = fall_cnt;
            if (it.de_en) begin
                exp_drop = te + it.lag;
                drop_valid = 1;
            end
            done++;
        end
    end

    task automatic send(int data, int len, int par, int stop, int lead, int lag,
                        bit de_en, bit b2b, bit scramble);
        item_t it;
        int elen;
        @(posedge clk); #1;
        in_data = 9'(data);
        cfg_data_len = 4'(len);
        cfg_parity = 2'(par);
        cfg_stop = 2'(stop);
        cfg_de_lead = 5'(lead);
        cfg_de_lag = 5'(lag);
        cfg_de_en = de_en;
        in_valid = 1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 0;
        elen = (len < 5) ? 5 : (len > 9) ? 9 : len;
        it.data = data;
        it.len = elen;
        it.par = par;
        it.stop_t = 8 * (stop + 1);
        it.lead_eff = (de_en && !b2b) ? lead : 0;
        it.lag = lag;
        it.de_en = de_en;
        it.b2b = b2b;
        it.acc_t = tcnt;
        q.push_back(it);
        sent++;
        if (scramble) begin
            cfg_data_len = 4'd5;
            cfg_parity = 2'd2;
            cfg_stop = 2'd0;
            cfg_de_lead = 5'd1;
            cfg_de_lag = 5'd0;
            cfg_de_en = 0;
            in_data = 9'h000;
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(done == sent && in_ready && de_log() == 1'b0));
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", done, sent);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R12 reset state (R1, R2 idle level)
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk(tx_out == 1'b1, "R2 idle line after reset", tx_out, 1);
        chk(de_out == 1'b0, "R8 DE inactive after reset", de_out, 0);

        send(9'h0A5, 8, 0, 1, 3, 2, 1, 0, 0);   wait_idle();   // 8N1
        send(9'h05B, 7, 2, 1, 0, 0, 1, 0, 0);   wait_idle();   // 7E1, zero lead/lag
        send(9'h13C, 9, 1, 3, 31, 31, 1, 0, 0); wait_idle();   // 9O2, max lead/lag
        send(9'h016, 5, 0, 0, 9, 9, 0, 0, 0);   wait_idle();   // R8 DE off, half stop
        send(9'h02D, 6, 2, 2, 5, 7, 1, 0, 0);                  // 6E1.5 then back-to-back
        send(9'h0C3, 8, 0, 1, 20, 4, 1, 1, 0);  wait_idle();   // R9
        send(9'h1E7, 9, 2, 3, 2, 6, 1, 0, 1);   wait_idle();   // R11 cfg scrambled mid-frame
        send(9'h1C3, 12, 1, 1, 1, 1, 1, 0, 0);  wait_idle();   // R3 clamp to 9
        send(9'h0E1, 2, 3, 1, 0, 3, 1, 0, 0);   wait_idle();   // R3 clamp to 5, R4 code 3

        // R10 polarity applied immediately, also while idle
        @(posedge clk); #1;
        cfg_tx_inv = 1; cfg_de_inv = 1; tx_inv_b = 1; de_inv_b = 1;
        @(negedge clk);
        chk(tx_out == 1'b0, "R10 inverted idle TX", tx_out, 0);
        chk(de_out == 1'b1, "R10 inverted idle DE", de_out, 1);
        send(9'h0F0, 8, 1, 1, 4, 3, 1, 0, 0);   wait_idle();
        @(posedge clk); #1;
        cfg_tx_inv = 0; cfg_de_inv = 0; tx_inv_b = 0; de_inv_b = 0;
        @(negedge clk);
        chk(tx_out == 1'b1 && de_out == 1'b0, "R10 normal polarity restored", {tx_out, de_out}, 2);

        chk(done == sent, "R1 all frames sent", done, sent);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule